// File: doc/BRIEF.md
# Serial Transmit Buffer and Framer

This block is the transmit half of a byte-oriented serial port that sits behind a register interface. Software writes a character into a single holding slot. The character then moves into a shift register, which frames it on the serial line: a low start bit, the data bits least significant first, and a high stop bit. Each bit lasts one period of an external bit-rate tick.

Two status flags tell software when it may write and when the line has gone quiet. The buffer-empty flag is high whenever the holding slot can take a character, and a write made while it is low is discarded. The transmit-complete flag rises when a frame finishes and nothing is waiting behind it. Either an interrupt acknowledge or a write-one-to-clear access to the status register clears it.

The character length is selectable from five to eight bits. When the holding slot is already full as a stop bit ends, the next start bit follows at once, so consecutive characters leave no idle time on the line.

Top module: `sertx_ctrl`

## Requirements
- R1: After reset, txd is high, dre is 1, tc is 0 and status reads 0x20.
- R2: A data write (wr_en) while dre is 0 is discarded: the buffered character that is sent later is the one held before that write.
- R3: A write while dre is 1 is accepted and dre reads 0 on the next cycle. dre returns to 1 on the cycle the character moves into an idle, enabled shift register, which is the cycle after the write.
- R4: A frame is a low start bit, then N data bits least significant first, then one high stop bit, each one bit_tick period long, with N = 5 + char_size (char_size 0..3 gives 5..8 bits). Bits of wr_data at index N and above do not appear on txd.
- R5: tc sets when a stop bit completes while the holding slot is empty. If the slot holds a character at that moment, tc does not set.
- R6: When a character is waiting as a stop bit completes, the next start bit begins on that same tick, with no idle bit between the frames.
- R7: tc clears on int_ack, or on stat_wr with stat_wdata bit 6 set. A status write with bit 6 clear leaves tc unchanged, and status writes never change dre.
- R8: While tx_en is 0, txd is high, no character moves into the shift register (dre stays 0 if the slot is full), and a frame in progress is abandoned without setting tc.
- R9: status carries tc at bit 6 and dre at bit 5, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Character written to the holding slot |
| tx_en | input | 1 | Transmitter enable |
| char_size | input | 2 | Character length select, 0..3 = 5..8 bits |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data, a one at bit 6 clears tc |
| int_ack | input | 1 | Transmit-complete interrupt acknowledge |
| txd | output | 1 | Serial output, idles high |
| dre | output | 1 | Holding slot empty, writes accepted |
| tc | output | 1 | Transmit complete flag |
| status | output | 8 | Status image: bit 6 tc, bit 5 dre |

## Verification
The assertions check the following on every cycle:
- a write to a full slot leaves the held character untouched;
- an accepted write drops dre on the next cycle;
- a disabled transmitter keeps txd high and never empties a full slot;
- a start bit follows a tick in the armed state;
- tc rises only at a frame end with an empty slot, and it falls after a clear.

The bench scenarios are the only way to show the serial content of each frame over all four character lengths, including the masking of the upper bits. They also show that back-to-back frames leave no gap, that tc stays low between chained frames, and that an abandoned frame leaves tc clear.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      SH_IDLE  = 3'd0,
      SH_ARM   = 3'd1,
      SH_START = 3'd2,
      SH_DATA  = 3'd3,
      SH_STOP  = 3'd4
   } sh_state_t;

   function automatic int size_bits(input int span);
      return (span > 1) ? $clog2(span) : 1;
   endfunction

endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5,
   parameter int SIZE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SIZE_W-1:0] char_size,
   input  logic              load,
   output logic              buf_full,
   output logic [DATA_W-1:0] buf_q
);

   logic [DATA_W-1:0] keep;
   logic              accept;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_keep
      if (gi < MIN_W) begin : g_always
         assign keep[gi] = 1'b1;
      end else begin : g_sized
         assign keep[gi] = ({1'b0, char_size} > (SIZE_W+1)'(gi - MIN_W));
      end
   end

   assign accept = wr_en && !buf_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_full <= 1'b0;
         buf_q    <= '0;
      end else begin
         if (accept) begin
            buf_full <= 1'b1;
            buf_q    <= wr_data & keep;
         end else if (load) begin
            buf_full <= 1'b0;
         end
      end
   end

   assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && buf_full) |=> $stable(buf_q));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5,
   parameter int SIZE_W = 2,
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              bit_tick,
   input  logic              buf_full,
   input  logic [DATA_W-1:0] buf_q,
   input  logic [SIZE_W-1:0] char_size,
   output logic              load,
   output logic              frame_end,
   output logic              txd
);

   localparam int SPAN = DATA_W - MIN_W + 1;

   sh_state_t         state;
   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  n_q;
   logic [CNT_W-1:0]  n_sel;
   logic [CNT_W:0]    n_raw;

   assign n_raw = (CNT_W+1)'(MIN_W) + (CNT_W+1)'(char_size);

   if ((2 ** SIZE_W) == SPAN) begin : g_exact
      assign n_sel = n_raw[CNT_W-1:0];
   end else begin : g_clamp
      assign n_sel = (n_raw > (CNT_W+1)'(DATA_W)) ? CNT_W'(DATA_W) : n_raw[CNT_W-1:0];
   end

   assign load = tx_en && buf_full &&
                 ((state == SH_IDLE) || ((state == SH_STOP) && bit_tick));
   assign frame_end = tx_en && (state == SH_STOP) && bit_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SH_IDLE;
         txd   <= 1'b1;
         sh    <= '0;
         cnt   <= '0;
         n_q   <= CNT_W'(DATA_W);
      end else if (!tx_en) begin
         state <= SH_IDLE;
         txd   <= 1'b1;
      end else begin
         case (state)
            SH_IDLE: begin
               if (load) begin
                  sh    <= buf_q;
                  n_q   <= n_sel;
                  state <= SH_ARM;
               end
            end
            SH_ARM: begin
               if (bit_tick) begin
                  txd   <= 1'b0;
                  state <= SH_START;
               end
            end
            SH_START: begin
               if (bit_tick) begin
                  txd   <= sh[0];
                  sh    <= sh >> 1;
                  cnt   <= CNT_W'(1);
                  state <= SH_DATA;
               end
            end
            SH_DATA: begin
               if (bit_tick) begin
                  if (cnt == n_q) begin
                     txd   <= 1'b1;
                     state <= SH_STOP;
                  end else begin
                     txd <= sh[0];
                     sh  <= sh >> 1;
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            SH_STOP: begin
               if (bit_tick) begin
                  if (load) begin
                     sh    <= buf_q;
                     n_q   <= n_sel;
                     txd   <= 1'b0;
                     state <= SH_START;
                  end else begin
                     state <= SH_IDLE;
                  end
               end
            end
            default: begin
               state <= SH_IDLE;
               txd   <= 1'b1;
            end
         endcase
      end
   end

   assert_off_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> txd);

   assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == SH_ARM) && bit_tick && tx_en) |=> !txd);

endmodule

// File: rtl/sertx_flags.sv
module sertx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_end,
   input  logic buf_full,
   input  logic int_ack,
   input  logic clr_req,
   output logic tc
);

   logic set_tc;
   logic clr_tc;

   assign set_tc = frame_end && !buf_full;
   assign clr_tc = int_ack || clr_req;

   always_ff @(posedge clk) begin
      if (!rst_n)       tc <= 1'b0;
      else if (set_tc)  tc <= 1'b1;
      else if (clr_tc)  tc <= 1'b0;
   end

   assert_tc_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc) |-> $past(frame_end && !buf_full));

   assert_tc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_tc && !frame_end) |=> !tc);

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
   import sertx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int MIN_W        = 5,
   parameter int REG_W        = 8,
   parameter int STAT_TC_BIT  = 6,
   parameter int STAT_DRE_BIT = 5,
   localparam int SIZE_W      = size_bits(DATA_W - MIN_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_en,
   input  logic [SIZE_W-1:0] char_size,
   input  logic              bit_tick,
   input  logic              stat_wr,
   input  logic [REG_W-1:0]  stat_wdata,
   input  logic              int_ack,
   output logic              txd,
   output logic              dre,
   output logic              tc,
   output logic [REG_W-1:0]  status
);

   if (MIN_W < 1 || MIN_W > DATA_W) begin : g_bad_min
      $error("MIN_W must lie between 1 and DATA_W");
   end
   if (STAT_TC_BIT >= REG_W || STAT_DRE_BIT >= REG_W || STAT_TC_BIT == STAT_DRE_BIT) begin : g_bad_bits
      $error("status bit positions must be distinct and inside REG_W");
   end

   logic              buf_full;
   logic [DATA_W-1:0] buf_q;
   logic              load;
   logic              frame_end;
   logic              clr_req;
   logic              stat_unused;

   assign clr_req     = stat_wr && stat_wdata[STAT_TC_BIT];
   assign stat_unused = ^stat_wdata;

   sertx_holdbuf #(.DATA_W(DATA_W), .MIN_W(MIN_W), .SIZE_W(SIZE_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .char_size (char_size),
      .load      (load),
      .buf_full  (buf_full),
      .buf_q     (buf_q)
   );

   sertx_shifter #(.DATA_W(DATA_W), .MIN_W(MIN_W), .SIZE_W(SIZE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .bit_tick  (bit_tick),
      .buf_full  (buf_full),
      .buf_q     (buf_q),
      .char_size (char_size),
      .load      (load),
      .frame_end (frame_end),
      .txd       (txd)
   );

   sertx_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .buf_full  (buf_full),
      .int_ack   (int_ack),
      .clr_req   (clr_req),
      .tc        (tc)
   );

   assign dre = !buf_full;

   always_comb begin
      status               = '0;
      status[STAT_TC_BIT]  = tc;
      status[STAT_DRE_BIT] = dre;
   end

   assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dre) |=> !dre);

   assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !dre) |=> !dre);

endmodule

// File: tb/sertx_ctrl_test.sv
module sertx_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n, wr_en, tx_en, bit_tick, stat_wr, int_ack;
   logic [7:0] wr_data, stat_wdata;
   logic [1:0] char_size;
   logic       txd, dre, tc;
   logic [7:0] status;

   always #10 clk = ~clk;

   sertx_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tx_en(tx_en), .char_size(char_size), .bit_tick(bit_tick),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata), .int_ack(int_ack),
      .txd(txd), .dre(dre), .tc(tc), .status(status)
   );

   int total = 0;
   int fails = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   // bit-rate tick: one cycle in four
   initial begin
      bit_tick = 1'b0;
      forever begin
         repeat (3) @(negedge clk);
         bit_tick = 1'b1;
         @(negedge clk);
         bit_tick = 1'b0;
      end
   end

   // line decoder: sample txd half a cycle after each tick edge
   logic tick_prev = 1'b0;
   always @(posedge clk) tick_prev <= bit_tick;

   int  nf = 0;
   int  frames [64];
   bit  stops  [64];
   int  gaps   [64];
   int  dstate = 0;
   int  kbit = 0;
   int  val = 0;
   int  gap = 0;
   int  gap_at = 0;
   int  cur_n = 8;
   bit  mon_clr = 0;

   always @(negedge clk) begin
      if (mon_clr) begin
         dstate = 0;
         gap    = 0;
      end else if (tick_prev) begin
         case (dstate)
            0: begin
               if (!txd) begin
                  dstate = 1; kbit = 0; val = 0; gap_at = gap;
               end else begin
                  gap++;
               end
            end
            1: begin
               val = val | (int'(txd) << kbit);
               kbit++;
               if (kbit == cur_n) dstate = 2;
            end
            default: begin
               if (nf < 64) begin
                  frames[nf] = val; stops[nf] = txd; gaps[nf] = gap_at;
               end
               nf++;
               gap = 0;
               dstate = 0;
            end
         endcase
      end
   end

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic swr(input logic [7:0] d);
      @(negedge clk);
      stat_wr = 1'b1; stat_wdata = d;
      @(negedge clk);
      stat_wr = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk);
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int p);
      case (p)
         0: return 8'h00;
         1: return 8'hFF;
         2: return 8'hA5;
         3: return 8'h5A;
         4: return 8'h80;
         5: return 8'h01;
         6: return 8'h0F;
         default: return 8'hE6;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      int base;
      bit early;
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tx_en = 1'b0;
      char_size = 2'd3; stat_wr = 1'b0; stat_wdata = '0; int_ack = 1'b0;
      waitn(3);
      chk(txd == 1'b1, "R1 txd", int'(txd), 1);
      chk(dre == 1'b1, "R1 dre", int'(dre), 1);
      chk(tc == 1'b0, "R1 tc", int'(tc), 0);
      chk(status == 8'h20, "R1 status", int'(status), 8'h20);
      rst_n = 1'b1; tx_en = 1'b1;
      waitn(2);

      // R3 dre timing and a single frame
      cur_n = 8; base = nf;
      @(negedge clk); wr_en = 1'b1; wr_data = 8'hC3;
      @(negedge clk); wr_en = 1'b0;
      chk(dre == 1'b0, "R3 dre after write", int'(dre), 0);
      @(negedge clk);
      chk(dre == 1'b1, "R3 dre after transfer", int'(dre), 1);
      waitn(60);
      chk(nf == base + 1, "R4 frame count", nf - base, 1);
      chk(frames[base] == 8'hC3 && stops[base], "R4 frame C3", frames[base], 8'hC3);
      chk(tc == 1'b1, "R5 tc after frame", int'(tc), 1);
      chk(status == 8'h60, "R9 status tc+dre", int'(status), 8'h60);

      // R7 write-one-to-clear
      swr(8'h20);
      chk(tc == 1'b1, "R7 bit6 zero keeps tc", int'(tc), 1);
      chk(dre == 1'b1, "R7 dre read-only", int'(dre), 1);
      swr(8'h40);
      chk(tc == 1'b0, "R7 bit6 one clears tc", int'(tc), 0);
      chk(status == 8'h20, "R9 status dre only", int'(status), 8'h20);

      // R4 sweep over character lengths and patterns
      for (int sz = 0; sz < 4; sz++) begin
         for (int p = 0; p < 8; p++) begin
            int n;
            int exp;
            n = 5 + sz;
            exp = int'(pat(p)) & ((1 << n) - 1);
            char_size = 2'(sz); cur_n = n; base = nf;
            wr(pat(p));
            waitn(60);
            chk(nf == base + 1 && frames[base] == exp && stops[base],
                $sformatf("R4 size %0d pattern %0d", n, p), frames[base], exp);
         end
      end
      chk(tc == 1'b1, "R5 tc after sweep", int'(tc), 1);
      ack();
      chk(tc == 1'b0, "R7 int_ack clears tc", int'(tc), 0);

      // R2 and R8: disabled transmitter holds the slot, extra write dropped
      char_size = 2'd3; cur_n = 8;
      tx_en = 1'b0; base = nf;
      wr(8'h5A);
      chk(dre == 1'b0, "R8 slot full while disabled", int'(dre), 0);
      wr(8'hA5);
      waitn(60);
      chk(dre == 1'b0, "R8 no transfer while disabled", int'(dre), 0);
      chk(nf == base && txd == 1'b1, "R8 line idle while disabled", nf - base, 0);
      tx_en = 1'b1;
      waitn(60);
      chk(nf == base + 1 && frames[base] == 8'h5A, "R2 dropped write", frames[base], 8'h5A);
      chk(dre == 1'b1, "R8 transfer after enable", int'(dre), 1);

      // R6 back-to-back frames, R5 no tc between them
      ack();
      base = nf;
      wr(8'h96);
      waitn(2);
      chk(dre == 1'b1, "R3 slot free during frame", int'(dre), 1);
      wr(8'h3C);
      early = 0;
      for (int c = 0; c < 140; c++) begin
         @(negedge clk);
         if (nf < base + 2 && tc) early = 1;
      end
      chk(nf == base + 2, "R6 two frames", nf - base, 2);
      chk(frames[base] == 8'h96, "R6 first frame", frames[base], 8'h96);
      chk(frames[base+1] == 8'h3C, "R6 second frame", frames[base+1], 8'h3C);
      chk(gaps[base+1] == 0, "R6 no idle bit between frames", gaps[base+1], 0);
      chk(early == 1'b0, "R5 no tc with data waiting", int'(early), 0);
      chk(tc == 1'b1, "R5 tc after last frame", int'(tc), 1);

      // R8 abandoned frame
      ack();
      base = nf;
      wr(8'h00);
      waitn(20);
      tx_en = 1'b0; mon_clr = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R8 txd high on disable", int'(txd), 1);
      waitn(60);
      chk(tc == 1'b0, "R8 no tc after abort", int'(tc), 0);
      chk(dre == 1'b1, "R8 slot empty after abort", int'(dre), 1);
      mon_clr = 1'b0; tx_en = 1'b1;
      waitn(60);
      chk(nf == base && txd == 1'b1, "R8 nothing resent", nf - base, 0);

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule